// File: doc/BRIEF.md
# Token-Steered Column Data Loader

This block fills a row of column registers with 6-bit gray-scale codes, one code per data strobe. A start pulse puts a single token at the first position of the walk. The token then moves one position for each strobe, and only the position that holds it captures the word on the data bus into its temporary register. Once the last active position has captured, the token leaves the block as a one-clock token-out pulse. That pulse can drive the start input of a second loader, so several loaders can be cascaded into one long row.

A latch strobe copies every temporary register into the output bank in a single clock. The output bank changes only on a latch, so the next line can be loaded while the current line is displayed. The walk can run in either direction. A reduced mode shortens the row from 200 to 192 active positions. Direction and mode are sampled when a walk starts.

Top module: `col_loader`

## Requirements
- R1: While rst_ni is low, every temporary and output register is cleared to 0, no token is held, and token_o is low.
- R2: A start is accepted only in a clock where strobe_i is high. In that same clock the first position of the walk captures data_i. A start_i pulse while strobe_i is low has no effect.
- R3: Each clock with strobe_i high, exactly the position holding the token writes data_i, and the token then moves one position. All other temporary registers keep their value.
- R4: With dir_i=0 the walk runs from the highest active position down to position 0. With dir_i=1 it runs from position 0 up to the highest active position. dir_i is sampled only at a start, so a change during a walk takes effect at the next start.
- R5: With reduced_i=1 at a start, the highest active position is 191 and positions 192 to 199 are never written during that walk. With reduced_i=0 it is 199.
- R6: token_o is high for exactly one clock, in the clock after the strobe that captured the last active position. At that point the internal token is cleared, and later strobes write nothing until the next start.
- R7: A start during a walk drops the old token and begins a new walk from the first position.
- R8: A clock with latch_i high copies all temporary registers into the output bank. Without latch_i the output bank holds its value. A latch in the same clock as a capture copies the value from before that capture.
- R9: Channel i of the output bank appears on out_o[i*6 +: 6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Data strobe; advances the token and enables capture |
| start_i | input | 1 | Token injection, qualified by strobe_i |
| dir_i | input | 1 | Walk direction: 0 = descending, 1 = ascending |
| reduced_i | input | 1 | 1 = 192 active positions, 0 = 200 |
| data_i | input | 6 | Gray-scale code to capture |
| latch_i | input | 1 | Copy the temporary bank into the output bank |
| token_o | output | 1 | One-clock cascade pulse at the end of the walk |
| out_o | output | 1200 | Output bank, 6 bits per channel |

## Verification
The bench loads full rows in both directions and in both modes. Before each row it leaves old data in positions 192 to 199, so a reduced walk that spills into them shows up as a changed channel. It also sends strobes after the token has left; a design that wraps the token or fails to clear it would overwrite channels. Other checks cover a direction change in the middle of a walk, a restart in the middle of a walk, and a start without a strobe; a design that samples dir_i on every clock, resumes the old token or accepts an unqualified start would land data in the wrong columns. A latch in the same clock as the final capture must show the value from before that capture; a design that forwards the new word would show it one latch early.

// File: rtl/col_loader_pkg.sv
package col_loader_pkg;
  typedef struct packed {
    logic up;
    logic reduced;
  } walk_cfg_t;
endpackage

// File: rtl/col_tok_ring.sv
module col_tok_ring
  import col_loader_pkg::*;
#(
  parameter int N_POS = 200,
  parameter int N_RED = 192
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             start_i,
  input  logic             dir_i,
  input  logic             reduced_i,
  output logic [N_POS-1:0] cap_o,
  output logic             token_o
);
  localparam int IW = $clog2(N_POS);

  logic [N_POS-1:0] tok_q, tok_d, cap;
  walk_cfg_t        cfg_q, cfg_eff;
  logic [IW-1:0]    top_idx, first_idx;
  logic             last_hit, tok_out_q;

  // config of the live walk; a start overrides it in its own cycle
  always_comb begin
    cfg_eff = cfg_q;
    if (start_i) begin
      cfg_eff.up      = dir_i;
      cfg_eff.reduced = reduced_i;
    end
  end

  assign top_idx   = cfg_eff.reduced ? IW'(N_RED - 1) : IW'(N_POS - 1);
  assign first_idx = cfg_eff.up ? '0 : top_idx;

  for (genvar i = 0; i < N_POS; i++) begin : g_pos
    logic up_src, dn_src;
    assign cap[i] = strobe_i & (start_i ? (IW'(i) == first_idx) : tok_q[i]);
    if (i > 0) begin : g_up
      assign up_src = cap[i-1] & (IW'(i - 1) != top_idx);
    end else begin : g_up0
      assign up_src = 1'b0;
    end
    if (i < N_POS - 1) begin : g_dn
      assign dn_src = cap[i+1];
    end else begin : g_dn0
      assign dn_src = 1'b0;
    end
    assign tok_d[i] = cfg_eff.up ? up_src : dn_src;
  end

  assign last_hit = cfg_eff.up ? cap[top_idx] : cap[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q     <= '0;
      cfg_q     <= '0;
      tok_out_q <= 1'b0;
    end else begin
      tok_out_q <= last_hit;
      if (strobe_i) tok_q <= tok_d;
      if (strobe_i && start_i) cfg_q <= cfg_eff;
    end
  end

  assign cap_o   = cap;
  assign token_o = tok_out_q;

  AST_TOK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tok_q)); // R3
  AST_ONE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cap_o)); // R3
  AST_TOKO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_o |=> !token_o); // R6
  AST_TOKO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_o |-> (tok_q == '0)); // R6
  AST_NO_TOK_NO_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && tok_q == '0) |-> (cap_o == '0)); // R6

  if (N_RED < N_POS) begin : g_red_chk
    AST_RED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i ? reduced_i : cfg_q.reduced) |-> (cap_o[N_POS-1:N_RED] == '0)); // R5
  end
endmodule

// File: rtl/col_tmp_bank.sv
module col_tmp_bank #(
  parameter int N_POS = 200,
  parameter int DW    = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_POS-1:0]    cap_i,
  input  logic [DW-1:0]       data_i,
  output logic [N_POS*DW-1:0] tmp_o
);
  for (genvar i = 0; i < N_POS; i++) begin : g_ch
    logic [DW-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       val_q <= '0;
      else if (cap_i[i]) val_q <= data_i;
    end
    assign tmp_o[i*DW +: DW] = val_q;

    AST_TMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_i[i] |=> $stable(tmp_o[i*DW +: DW])); // R3
  end
endmodule

// File: rtl/col_out_bank.sv
module col_out_bank #(
  parameter int N_POS = 200,
  parameter int DW    = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                latch_i,
  input  logic [N_POS*DW-1:0] tmp_i,
  output logic [N_POS*DW-1:0] out_o
);
  logic [N_POS*DW-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      out_q <= '0;
    else if (latch_i) out_q <= tmp_i;
  end

  assign out_o = out_q;

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(out_o)); // R8
endmodule

// File: rtl/col_loader.sv
module col_loader
  import col_loader_pkg::*;
#(
  parameter int N_POS = 200,
  parameter int N_RED = 192,
  parameter int DW    = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                strobe_i,
  input  logic                start_i,
  input  logic                dir_i,
  input  logic                reduced_i,
  input  logic [DW-1:0]       data_i,
  input  logic                latch_i,
  output logic                token_o,
  output logic [N_POS*DW-1:0] out_o
);
  logic [N_POS-1:0]    cap;
  logic [N_POS*DW-1:0] tmp;

  col_tok_ring #(.N_POS(N_POS), .N_RED(N_RED)) u_ring (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .start_i  (start_i),
    .dir_i    (dir_i),
    .reduced_i(reduced_i),
    .cap_o    (cap),
    .token_o  (token_o)
  );

  col_tmp_bank #(.N_POS(N_POS), .DW(DW)) u_tmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .data_i (data_i),
    .tmp_o  (tmp)
  );

  col_out_bank #(.N_POS(N_POS), .DW(DW)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .latch_i(latch_i),
    .tmp_i  (tmp),
    .out_o  (out_o)
  );

  AST_RST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !token_o); // R1
endmodule

// File: tb/col_loader_bench.sv
`timescale 1ns/1ps
module col_loader_bench;
  localparam int N   = 200;
  localparam int NR  = 192;
  localparam int DW  = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic strobe = 0, start = 0, dir = 0, red = 0, latch = 0;
  logic [DW-1:0] data = '0;
  logic token;
  logic [N*DW-1:0] bank;

  col_loader u_col_loader (
    .clk_i(clk), .rst_ni(rst_ni), .strobe_i(strobe), .start_i(start),
    .dir_i(dir), .reduced_i(red), .data_i(data), .latch_i(latch),
    .token_o(token), .out_o(bank)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int tmp_m [N];
  int out_m [N];
  bit m_live = 0, m_up = 0, m_tok = 0;
  int m_pos = 0, m_act = N;

  // {up, reduced, seed[5:0], length[7:0]}
  localparam logic [15:0] VEC [6] = '{
    {1'b0, 1'b0, 6'd5,  8'd200},
    {1'b1, 1'b0, 6'd17, 8'd200},
    {1'b0, 1'b1, 6'd33, 8'd192},
    {1'b1, 1'b1, 6'd50, 8'd192},
    {1'b0, 1'b0, 6'd9,  8'd200},
    {1'b1, 1'b1, 6'd2,  8'd192}
  };

  task automatic step(input logic en, input logic st, input logic [DW-1:0] d,
                      input logic lat, input logic up, input logic rd);
    @(negedge clk);
    strobe = en; start = st; data = d; latch = lat; dir = up; red = rd;
    @(posedge clk);
    if (lat) for (int i = 0; i < N; i++) out_m[i] = tmp_m[i];
    m_tok = 0;
    if (en) begin
      if (st) begin
        m_up = up; m_act = rd ? NR : N;
        m_pos = up ? 0 : m_act - 1; m_live = 1;
      end
      if (m_live) begin
        tmp_m[m_pos] = int'(d);
        if (m_up ? (m_pos == m_act - 1) : (m_pos == 0)) begin
          m_tok = 1; m_live = 0;
        end else m_pos += m_up ? 1 : -1;
      end
    end
    #1;
    checks++;
    if (token !== m_tok) begin
      fails++;
      $display("FAIL R6 token_o got %0b exp %0b", token, m_tok);
    end
  endtask

  task automatic idle();
    step(0, 0, '0, 0, dir, red);
  endtask

  // R9: channel i sits at bank[i*DW +: DW]
  task automatic check_bank(input string tag);
    int bad;
    bad = -1;
    for (int i = 0; i < N; i++)
      if (bad < 0 && int'(bank[i*DW +: DW]) != out_m[i]) bad = i;
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s ch%0d got %0d exp %0d", tag, bad,
               bank[bad*DW +: DW], out_m[bad]);
    end
  endtask

  initial begin
    #(8ns * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin tmp_m[i] = 0; out_m[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (token !== 1'b0 || bank !== '0) begin
      fails++;
      $display("FAIL R1 reset token %0b bank nonzero=%0b exp 0", token, |bank);
    end
    @(negedge clk) rst_ni = 1'b1;

    // table-driven full-row loads
    for (int v = 0; v < 6; v++) begin
      logic up, rd;
      logic [5:0] seed;
      int len;
      bit seen;
      up = VEC[v][15]; rd = VEC[v][14]; seed = VEC[v][13:8]; len = int'(VEC[v][7:0]);
      seen = 0;
      for (int k = 0; k < len; k++) begin
        step(1, k == 0, DW'(int'(seed) + 7 * k), 0, up, rd);
        if (k == len - 1) seen = token;
      end
      checks++;
      if (!seen) begin
        fails++;
        $display("FAIL R6 walk length: token_o got 0 exp 1 after %0d strobes", len);
      end
      check_bank("R8 hold-without-latch");
      step(0, 0, '0, 1, up, rd);
      check_bank(up ? "R4/R5 ascending" : "R4/R5 descending");
    end

    // R6: strobes after the token left write nothing
    repeat (5) step(1, 0, 6'd63, 0, 0, 0);
    step(0, 0, '0, 1, 0, 0);
    check_bank("R6 overrun");

    // R2: start without strobe is ignored
    step(0, 1, 6'd44, 0, 1, 0);
    repeat (3) step(1, 0, 6'd11, 0, 1, 0);
    step(0, 0, '0, 1, 1, 0);
    check_bank("R2 unqualified start");

    // R4: direction change mid-walk waits for next start
    step(1, 1, 6'd21, 0, 0, 0);
    for (int k = 1; k < 3; k++) step(1, 0, DW'(21 + k), 0, 0, 0);
    for (int k = 3; k < N; k++) step(1, 0, DW'(3 * k), 0, 1, 1);
    step(0, 0, '0, 1, 1, 0);
    check_bank("R4 mid-walk dir change");

    // R7: restart during a walk
    for (int k = 0; k < 10; k++) step(1, k == 0, DW'(40 + k), 0, 1, 0);
    for (int k = 0; k < N; k++) step(1, k == 0, DW'(5 * k + 1), 0, 1, 0);
    step(0, 0, '0, 1, 1, 0);
    check_bank("R7 restart");

    // R8: latch in the same cycle as the final capture sees the old value
    for (int k = 0; k < NR - 1; k++) step(1, k == 0, DW'(k + 3), 0, 1, 1);
    step(1, 0, 6'd60, 1, 1, 1);
    check_bank("R8 latch with capture");
    step(0, 0, '0, 1, 1, 1);
    check_bank("R9 layout after relatch");
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule